// File: doc/BRIEF.md
# Receive Descriptor Status Write-Back Generator

This block sits at the tail of a receive MAC and turns the events of one incoming frame into the 16-bit status word and the length value that get written back into that frame's receive descriptor. It counts the bytes of the frame, including the 4-byte FCS, and collects the error indications raised while the frame arrives. At the end of the frame it adds the end-of-frame results: CRC check, dribble nibble, address-filter hits and whether a descriptor was available. It then classifies the frame against the runt, maximum and buffer-size limits.

When a descriptor is available, the block presents status and length together with a one-cycle write-back strobe. The ownership bit in that word is cleared, which hands the descriptor back to software. A receive-finished pulse follows one cycle later. When no descriptor is available, the block raises a one-cycle no-descriptor event instead, and neither the write-back nor the finished pulse occurs. Descriptor fetch and payload movement are handled elsewhere.

Top module: `rx_status_gen`

## Requirements
- R1: While rst_ni is low, wb_vld_o, rx_done_o and no_desc_o are 0, and so are wb_status_o and wb_len_o.
- R2: wb_len_o equals the number of cycles with byte_vld_i high, counted from the cycle after the previous eof_i through the eof_i cycle inclusive. The FCS is included in this count, and the count saturates at 2^LEN_W-1.
- R3: When eof_i is high and desc_avail_i is high at a clock edge, wb_vld_o is high for exactly the next cycle, and in that write-back bit 15 (ownership) is 0.
- R4: rx_done_o is high for one cycle, in the cycle right after each wb_vld_o cycle, and at no other time.
- R5: Bit 7 (runt) is set when the length is below MIN_LEN (64).
- R6: Bit 8 (long) is set when the length exceeds MAX_LEN (1518).
- R7: Bit 9 (buffer exceeded) is set when the length exceeds buf_size_i, or when ovf_i was high in any cycle of the frame.
- R8: Bit 10 (dribble) and bit 6 (CRC error) copy dribble_i and crc_err_i as sampled in the eof_i cycle. The values of these inputs in other cycles have no effect.
- R9: Bit 11 (summary error) is the OR of bits 10..6 and of phy_err_i being high in any cycle of the frame. Bit 14 (OK) is the inverse of bit 11. Bits 13 and 12 are 0.
- R10: When the frame is OK, bit 5 = bcast_i, bit 4 = mcast_i, bit 3 = hash_hit_i, bit 2 = mid_hit_i, and bits 1:0 = mid_idx_i when mid_hit_i is set and 0 otherwise, all sampled at eof_i. When the frame has an error, bits 5..0 are 0.
- R11: When eof_i is high and desc_avail_i is low at a clock edge, no_desc_o is high for exactly the next cycle, and neither wb_vld_o nor rx_done_o results from that frame.
- R12: Byte count and sticky error state restart after every eof_i, so nothing from one frame appears in the status or length of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buf_size_i | input | LEN_W | Programmed receive buffer size in bytes |
| byte_vld_i | input | 1 | One frame byte received this cycle |
| eof_i | input | 1 | Last cycle of the frame |
| phy_err_i | input | 1 | PHY receive error, any cycle of the frame |
| ovf_i | input | 1 | Buffer overflow indication, any cycle of the frame |
| crc_err_i | input | 1 | FCS check failed, valid with eof_i |
| dribble_i | input | 1 | Dribble nibble seen, valid with eof_i |
| desc_avail_i | input | 1 | Hardware-owned descriptor present, valid with eof_i |
| bcast_i | input | 1 | Broadcast destination, valid with eof_i |
| mcast_i | input | 1 | Multicast destination, valid with eof_i |
| hash_hit_i | input | 1 | Multicast hash hit, valid with eof_i |
| mid_hit_i | input | 1 | Exact address table hit, valid with eof_i |
| mid_idx_i | input | 2 | Index of matching address table entry |
| wb_vld_o | output | 1 | Write-back strobe, one cycle |
| wb_status_o | output | 16 | Descriptor status word |
| wb_len_o | output | LEN_W | Frame length including FCS |
| rx_done_o | output | 1 | Receive-finished pulse |
| no_desc_o | output | 1 | Frame ended with no descriptor available |

## Verification
Two functions can fall in the same cycle: a write-back for a new frame and the finished pulse of the previous frame. A frame's final byte can also coincide with its eof_i, and a sticky phy_err_i or ovf_i pulse can arrive in the eof_i cycle itself. The bench provokes the first case with back-to-back frames whose eof_i cycles are adjacent, and the second by putting the last byte and late error pulses on the eof_i cycle. A per-cycle monitor then judges each cycle against a queue of expected write-backs and a one-cycle-delayed copy of the strobe, so it catches a merged or dropped pulse as well as a wrong field.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int ST_OWN   = 15;
  localparam int ST_OK    = 14;
  localparam int ST_ERR   = 11;
  localparam int ST_DRIB  = 10;
  localparam int ST_BUFX  = 9;
  localparam int ST_LONG  = 8;
  localparam int ST_RUNT  = 7;
  localparam int ST_CRC   = 6;
  localparam int ST_BCAST = 5;
  localparam int ST_MCAST = 4;
  localparam int ST_HASH  = 3;
  localparam int ST_MID   = 2;

  typedef struct packed {
    logic       bcast;
    logic       mcast;
    logic       hash_hit;
    logic       mid_hit;
    logic [1:0] mid_idx;
  } rx_filt_t;

  typedef struct packed {
    logic drib;
    logic bufx;
    logic lng;
    logic runt;
    logic crc;
  } rx_errs_t;
endpackage

// File: rtl/rxs_frame_acc.sv
module rxs_frame_acc #(
  parameter int LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_vld_i,
  input  logic             eof_i,
  input  logic             phy_err_i,
  input  logic             ovf_i,
  output logic [LEN_W-1:0] len_o,
  output logic             phy_o,
  output logic             ovf_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] cnt_q, cnt_nxt;
  logic             phy_q, ovf_q;

  // saturating count, includes a byte arriving with eof
  always_comb begin
    cnt_nxt = cnt_q;
    if (byte_vld_i && cnt_q != CNT_MAX) cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      phy_q <= 1'b0;
      ovf_q <= 1'b0;
    end else if (eof_i) begin
      cnt_q <= '0;
      phy_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      phy_q <= phy_q | phy_err_i;
      ovf_q <= ovf_q | ovf_i;
    end
  end

  assign len_o = cnt_nxt;
  assign phy_o = phy_q | phy_err_i;
  assign ovf_o = ovf_q | ovf_i;
endmodule

// File: rtl/rxs_classify.sv
module rxs_classify
  import rxs_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] buf_size_i,
  input  logic             phy_i,
  input  logic             ovf_i,
  input  logic             crc_i,
  input  logic             drib_i,
  input  rx_filt_t         filt_i,
  output logic [15:0]      status_o
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  rx_errs_t errs;
  logic     any_err;

  always_comb begin
    errs.runt = len_i < MIN_L;
    errs.lng  = len_i > MAX_L;
    errs.bufx = (len_i > buf_size_i) | ovf_i;
    errs.crc  = crc_i;
    errs.drib = drib_i;
    any_err   = (|errs) | phy_i;
  end

  always_comb begin
    status_o           = '0;
    status_o[ST_OWN]   = 1'b0;
    status_o[ST_OK]    = ~any_err;
    status_o[ST_ERR]   = any_err;
    status_o[ST_DRIB]  = errs.drib;
    status_o[ST_BUFX]  = errs.bufx;
    status_o[ST_LONG]  = errs.lng;
    status_o[ST_RUNT]  = errs.runt;
    status_o[ST_CRC]   = errs.crc;
    // address class only reported for good frames
    if (!any_err) begin
      status_o[ST_BCAST] = filt_i.bcast;
      status_o[ST_MCAST] = filt_i.mcast;
      status_o[ST_HASH]  = filt_i.hash_hit;
      status_o[ST_MID]   = filt_i.mid_hit;
      status_o[1:0]      = filt_i.mid_hit ? filt_i.mid_idx : 2'b00;
    end
  end
endmodule

// File: rtl/rxs_wb_seq.sv
module rxs_wb_seq #(
  parameter int LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eof_i,
  input  logic             desc_avail_i,
  input  logic [15:0]      status_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             wb_vld_o,
  output logic [15:0]      wb_status_o,
  output logic [LEN_W-1:0] wb_len_o,
  output logic             rx_done_o,
  output logic             no_desc_o
);
  logic             wb_q, done_q, nod_q;
  logic [15:0]      st_q;
  logic [LEN_W-1:0] len_q;
  logic             take;

  assign take = eof_i & desc_avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_q   <= 1'b0;
      done_q <= 1'b0;
      nod_q  <= 1'b0;
      st_q   <= '0;
      len_q  <= '0;
    end else begin
      wb_q   <= take;
      done_q <= wb_q;
      nod_q  <= eof_i & ~desc_avail_i;
      if (take) begin
        st_q  <= status_i;
        len_q <= len_i;
      end
    end
  end

  assign wb_vld_o    = wb_q;
  assign wb_status_o = st_q;
  assign wb_len_o    = len_q;
  assign rx_done_o   = done_q;
  assign no_desc_o   = nod_q;
endmodule

// File: rtl/rx_status_gen.sv
module rx_status_gen
  import rxs_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] buf_size_i,
  input  logic             byte_vld_i,
  input  logic             eof_i,
  input  logic             phy_err_i,
  input  logic             ovf_i,
  input  logic             crc_err_i,
  input  logic             dribble_i,
  input  logic             desc_avail_i,
  input  logic             bcast_i,
  input  logic             mcast_i,
  input  logic             hash_hit_i,
  input  logic             mid_hit_i,
  input  logic [1:0]       mid_idx_i,
  output logic             wb_vld_o,
  output logic [15:0]      wb_status_o,
  output logic [LEN_W-1:0] wb_len_o,
  output logic             rx_done_o,
  output logic             no_desc_o
);
  logic [LEN_W-1:0] frm_len;
  logic             frm_phy, frm_ovf;
  logic [15:0]      frm_status;
  rx_filt_t         filt;

  assign filt = '{bcast: bcast_i, mcast: mcast_i, hash_hit: hash_hit_i,
                  mid_hit: mid_hit_i, mid_idx: mid_idx_i};

  rxs_frame_acc #(.LEN_W(LEN_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld_i),
    .eof_i      (eof_i),
    .phy_err_i  (phy_err_i),
    .ovf_i      (ovf_i),
    .len_o      (frm_len),
    .phy_o      (frm_phy),
    .ovf_o      (frm_ovf)
  );

  rxs_classify #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_cls (
    .len_i      (frm_len),
    .buf_size_i (buf_size_i),
    .phy_i      (frm_phy),
    .ovf_i      (frm_ovf),
    .crc_i      (crc_err_i),
    .drib_i     (dribble_i),
    .filt_i     (filt),
    .status_o   (frm_status)
  );

  rxs_wb_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .eof_i        (eof_i),
    .desc_avail_i (desc_avail_i),
    .status_i     (frm_status),
    .len_i        (frm_len),
    .wb_vld_o     (wb_vld_o),
    .wb_status_o  (wb_status_o),
    .wb_len_o     (wb_len_o),
    .rx_done_o    (rx_done_o),
    .no_desc_o    (no_desc_o)
  );
endmodule

// File: rtl/rx_status_gen_chk.sv
module rx_status_gen_chk #(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             eof_i,
  input logic             desc_avail_i,
  input logic             wb_vld_o,
  input logic [15:0]      wb_status_o,
  input logic [LEN_W-1:0] wb_len_o,
  input logic             rx_done_o,
  input logic             no_desc_o
);
  // R3
  wb_own_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_vld_o |-> !wb_status_o[15]);
  // R3
  wb_after_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_vld_o |-> $past(eof_i && desc_avail_i));
  // R4
  done_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_vld_o |=> rx_done_o);
  // R4
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> $past(wb_vld_o));
  // R5
  runt_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_vld_o && wb_len_o < LEN_W'(MIN_LEN)) |-> wb_status_o[7]);
  // R9
  ok_vs_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_vld_o |-> (wb_status_o[14] != wb_status_o[11]));
  // R9
  err_summary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_vld_o && (|wb_status_o[10:6])) |-> wb_status_o[11]);
  // R10
  filt_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_vld_o && wb_status_o[11]) |-> (wb_status_o[5:0] == 6'd0));
  // R11
  no_desc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_desc_o |-> ($past(eof_i && !desc_avail_i) && !wb_vld_o));
endmodule

bind rx_status_gen rx_status_gen_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .eof_i        (eof_i),
  .desc_avail_i (desc_avail_i),
  .wb_vld_o     (wb_vld_o),
  .wb_status_o  (wb_status_o),
  .wb_len_o     (wb_len_o),
  .rx_done_o    (rx_done_o),
  .no_desc_o    (no_desc_o)
);

// File: tb/rx_status_gen_bench.sv
module rx_status_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 14;
  localparam int SAT   = (1 << LEN_W) - 1;

  typedef struct {
    bit          nodesc;
    logic [15:0] st;
    int          len;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LEN_W-1:0] buf_size = 14'h600;
  logic byte_vld = 0, eof = 0, phy_err = 0, ovf = 0, crc_err = 0, dribble = 0;
  logic desc_avail = 0, bcast = 0, mcast = 0, hash_hit = 0, mid_hit = 0;
  logic [1:0] mid_idx = 0;
  logic wb_vld, rx_done, no_desc;
  logic [15:0] wb_status;
  logic [LEN_W-1:0] wb_len;

  int checks = 0, errors = 0;
  bit run = 0, prev_wb = 0, finished = 0;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_status_gen u_rx_status_gen (
    .clk_i(clk), .rst_ni(rst_n), .buf_size_i(buf_size), .byte_vld_i(byte_vld),
    .eof_i(eof), .phy_err_i(phy_err), .ovf_i(ovf), .crc_err_i(crc_err),
    .dribble_i(dribble), .desc_avail_i(desc_avail), .bcast_i(bcast),
    .mcast_i(mcast), .hash_hit_i(hash_hit), .mid_hit_i(mid_hit),
    .mid_idx_i(mid_idx), .wb_vld_o(wb_vld), .wb_status_o(wb_status),
    .wb_len_o(wb_len), .rx_done_o(rx_done), .no_desc_o(no_desc));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_st(int n, bit phy, bit ov, bit crc, bit drib,
      bit bc, bit mc, bit hh, bit mh, logic [1:0] idx, int bsz);
    int  len = (n > SAT) ? SAT : n;
    bit  runt = len < 64;
    bit  lng  = len > 1518;
    bit  bx   = (len > bsz) || ov;
    bit  err  = phy || runt || lng || bx || crc || drib;
    logic [15:0] s = '0;
    s[10] = drib; s[9] = bx; s[8] = lng; s[7] = runt; s[6] = crc;
    s[11] = err; s[14] = !err;
    if (!err) begin
      s[5] = bc; s[4] = mc; s[3] = hh; s[2] = mh;
      if (mh) s[1:0] = idx;
    end
    return s;
  endfunction

  // monitor: sampled on falling edge, away from the active edge
  always @(negedge clk) begin
    if (run) begin
      exp_t e;
      chk("R4 done pulse", int'(rx_done), int'(prev_wb));
      prev_wb = wb_vld;
      if (wb_vld || no_desc) begin
        if (expq.size() == 0) begin
          chk("R3 unexpected strobe", 1, 0);
        end else begin
          e = expq.pop_front();
          if (e.nodesc) begin
            chk("R11 no_desc", int'(no_desc), 1);
            chk("R11 no wb", int'(wb_vld), 0);
          end else begin
            chk("R3 wb strobe", int'(wb_vld), 1);
            chk("R11 no_desc idle", int'(no_desc), 0);
            chk("R3 own bit", int'(wb_status[15]), 0);
            chk("R2 length", int'(wb_len), (e.len > SAT) ? SAT : e.len);
            chk("R5 runt", int'(wb_status[7]), int'(e.st[7]));
            chk("R6 long", int'(wb_status[8]), int'(e.st[8]));
            chk("R7 bufx", int'(wb_status[9]), int'(e.st[9]));
            chk("R8 drib/crc", int'({wb_status[10], wb_status[6]}), int'({e.st[10], e.st[6]}));
            chk("R9 ok/err", int'(wb_status[14:11]), int'(e.st[14:11]));
            chk("R10 filter", int'(wb_status[5:0]), int'(e.st[5:0]));
          end
        end
      end
    end
  end

  task automatic noise();
    crc_err = 1'($urandom); dribble = 1'($urandom); desc_avail = 1'($urandom);
    bcast = 1'($urandom); mcast = 1'($urandom); hash_hit = 1'($urandom);
    mid_hit = 1'($urandom); mid_idx = 2'($urandom);
  endtask

  task automatic frame(int n, bit avail, bit crc, bit drib, int phy_pos, int ovf_pos,
      bit bc, bit mc, bit hh, bit mh, logic [1:0] idx, bit gaps);
    exp_t e;
    bit ph = (phy_pos >= 0) && (phy_pos < n);
    bit ov = (ovf_pos >= 0) && (ovf_pos < n);
    e.nodesc = !avail;
    e.len    = n;
    e.st     = exp_st(n, ph, ov, crc, drib, bc, mc, hh, mh, idx, int'(buf_size));
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 2 == 1)) begin
        byte_vld = 0; eof = 0; phy_err = 0; ovf = 0; noise();
        @(negedge clk);
      end
      byte_vld = 1; phy_err = (i == phy_pos); ovf = (i == ovf_pos);
      if (i == n - 1) begin
        eof = 1; crc_err = crc; dribble = drib; desc_avail = avail;
        bcast = bc; mcast = mc; hash_hit = hh; mid_hit = mh; mid_idx = idx;
        expq.push_back(e);
      end else begin
        eof = 0; noise();
      end
      @(negedge clk);
    end
    if (n == 0) begin
      byte_vld = 0; phy_err = 0; ovf = 0; eof = 1;
      crc_err = crc; dribble = drib; desc_avail = avail;
      bcast = bc; mcast = mc; hash_hit = hh; mid_hit = mh; mid_idx = idx;
      expq.push_back(e);
      @(negedge clk);
    end
    byte_vld = 0; eof = 0; phy_err = 0; ovf = 0; noise();
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wb_vld", int'(wb_vld), 0);
    chk("R1 rx_done", int'(rx_done), 0);
    chk("R1 no_desc", int'(no_desc), 0);
    chk("R1 status", int'(wb_status), 0);
    chk("R1 len", int'(wb_len), 0);
    rst_n = 1;
    run = 1;
    idle(2);

    frame(100, 1, 0, 0, -1, -1, 1, 0, 0, 0, 2'd0, 0);     // R3 clean broadcast
    idle(3);
    frame(63, 1, 0, 0, -1, -1, 0, 1, 0, 0, 2'd0, 0);      // R5 runt edge
    frame(64, 1, 0, 0, -1, -1, 0, 1, 1, 0, 2'd0, 1);      // R5 boundary ok
    frame(1518, 1, 0, 0, -1, -1, 0, 0, 0, 1, 2'd3, 0);    // R6 boundary ok
    frame(1519, 1, 0, 0, -1, -1, 1, 0, 0, 0, 2'd0, 0);    // R6 long
    buf_size = 14'd1000;
    frame(1000, 1, 0, 0, -1, -1, 0, 0, 0, 1, 2'd1, 0);    // R7 equal size ok
    frame(1001, 1, 0, 0, -1, -1, 0, 0, 0, 0, 2'd0, 0);    // R7 exceeded
    buf_size = 14'h600;
    frame(200, 1, 0, 0, -1, 0, 1, 1, 1, 1, 2'd2, 0);      // R7 overflow pulse
    frame(80, 1, 1, 0, -1, -1, 1, 0, 0, 0, 2'd0, 0);      // R8 crc
    frame(80, 1, 0, 1, -1, -1, 0, 1, 0, 0, 2'd0, 1);      // R8 dribble
    frame(90, 1, 0, 0, 89, -1, 1, 0, 0, 0, 2'd0, 0);      // R9 phy error on eof cycle
    frame(90, 1, 0, 0, -1, 89, 0, 0, 0, 0, 2'd0, 0);      // R7 overflow on eof cycle
    frame(70, 1, 0, 0, -1, -1, 0, 0, 0, 0, 2'd3, 0);      // R10 idx hidden without hit
    frame(120, 0, 0, 0, -1, -1, 1, 0, 0, 0, 2'd0, 0);     // R11 no descriptor
    frame(120, 1, 1, 1, 5, 7, 1, 1, 1, 1, 2'd3, 0);       // R12 all errors
    frame(120, 1, 0, 0, -1, -1, 0, 0, 1, 1, 2'd1, 0);     // R12 next frame clean
    frame(0, 1, 0, 0, -1, -1, 0, 0, 0, 0, 2'd0, 0);       // R4 back-to-back eofs
    frame(0, 1, 0, 0, -1, -1, 0, 0, 0, 0, 2'd0, 0);
    frame(0, 0, 0, 0, -1, -1, 0, 0, 0, 0, 2'd0, 0);
    frame(1, 1, 0, 0, -1, -1, 1, 0, 0, 0, 2'd0, 0);
    idle(2);
    buf_size = 14'h3FFF;
    frame(SAT + 20, 1, 0, 0, -1, -1, 0, 0, 0, 0, 2'd0, 0); // R2 saturation
    buf_size = 14'h600;
    idle(2);

    for (int k = 0; k < 30; k++) begin
      int sel = int'($urandom_range(0, 3));
      int n = (sel == 0) ? int'($urandom_range(0, 80)) :
              (sel == 1) ? int'($urandom_range(1500, 1600)) :
                           int'($urandom_range(60, 1520));
      int pp = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 1600)) : -1;
      int op = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 1600)) : -1;
      bit av = ($urandom_range(0, 9) != 0);
      bit cr = ($urandom_range(0, 5) == 0);
      bit dr = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 3) == 0) buf_size = 14'($urandom_range(64, 1600));
      else buf_size = 14'h600;
      frame(n, av, cr, dr, pp, op, 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 2'($urandom), 1'($urandom));
      if ($urandom_range(0, 1) == 0) idle(int'($urandom_range(1, 3)));
    end

    idle(4);
    chk("R3 all write-backs seen", expq.size(), 0);
    finish_run();
  end
endmodule